// File: doc/BRIEF.md
# Pipeline Freeze and Bubble Stall Controller

This block makes the stall decisions for an in-order pipeline. When the instruction in decode cannot proceed, it freezes the fetch and decode stages and inserts a bubble into execute in place of the stalled instruction. The pipeline register's valid bit is cleared to form the bubble. The same action covers three kinds of wait. The first is short hazards reported by the hazard checks, load-use among them. The second is an open-ended wait while a multiply/divide unit is busy and decode wants its HI/LO result. The third is a break instruction that holds in decode until an external release line pulses.

An exception flush outranks every stall. It clears the valid bits of the younger stages and keeps fetch frozen until the exception is reported resolved. The controller is purely a decision block. Hazard detection and the multiply/divide unit sit outside it, and the outputs drive the enables and valid-clear inputs of the pipeline registers directly.

Top module: `pipe_stall_ctrl`

## Requirements
- R1: After reset, with no exception and no stall condition present, if_freeze_o, id_freeze_o, ex_bubble_o and flush_o are all 0.
- R2: When id_valid_i is 1 and any bit of haz_stall_i is 1, and no exception is active, if_freeze_o, id_freeze_o and ex_bubble_o are 1 in that same cycle. With id_valid_i at 0, the hazard bits have no effect.
- R3: When id_valid_i, id_rd_hilo_i and md_busy_i are all 1 and no exception is active, decode stalls (all three stall outputs 1) for as many cycles as md_busy_i stays 1. md_busy_i without id_rd_hilo_i causes no stall.
- R4: A valid break in decode (id_is_brk_i=1) stalls while it waits. A release_i pulse in a cycle where the break is waiting ends the stall from the next cycle on.
- R5: release_i is ignored whenever no break is waiting in decode, so a break that arrives later still stalls for at least one cycle.
- R6: Once a released break leaves decode (a cycle with id_freeze_o=0), the release is consumed, and the next break waits again.
- R7: In a cycle with exc_flush_i=1, flush_o=1 and if_freeze_o=1 while id_freeze_o=0 and ex_bubble_o=0, whatever stall conditions are present.
- R8: After an exc_flush_i pulse, flush_o and if_freeze_o stay 1 up to and including the cycle in which exc_resolved_i is 1, and drop in the following cycle. If a flush and a resolve arrive together, the flush wins.
- R9: A flush discards a release that a break has already received, so a break seen in decode after the exception stalls again.
- R10: While an exception is active (a flush pulse or a pending exception), hazard, HI/LO and break conditions do not assert id_freeze_o or ex_bubble_o, and release_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Decode stage holds a valid instruction |
| haz_stall_i | input | NUM_HAZ | Per-source "cannot proceed" flags from hazard checks |
| id_rd_hilo_i | input | 1 | Decode instruction reads HI or LO |
| md_busy_i | input | 1 | Multiply/divide unit still busy |
| id_is_brk_i | input | 1 | Decode instruction is a break |
| release_i | input | 1 | External release line for a waiting break |
| exc_flush_i | input | 1 | Exception flush request (pulse) |
| exc_resolved_i | input | 1 | Exception handling finished (pulse) |
| if_freeze_o | output | 1 | Hold the fetch stage and PC |
| id_freeze_o | output | 1 | Hold the fetch/decode pipeline register |
| ex_bubble_o | output | 1 | Clear the valid bit entering execute |
| flush_o | output | 1 | Clear the valid bits of the younger stages |

## Verification
The bench builds the block with NUM_HAZ=4. This makes the reduction span several generate stages, and it lets hazard bits other than bit 0 trigger a stall on their own. The random stimulus biases the multiply/divide busy flag and the break flag to stay asserted across many cycles. This produces long open-ended waits, release pulses that land both inside and outside a waiting break, and flushes that arrive while a break is waiting or has already been released. Directed sequences pin down the exact cycles of release, consumption, flush priority and resolution.

// File: rtl/stall_pkg.sv
package stall_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_HAZ  = 3'd1,
    CAUSE_HILO = 3'd2,
    CAUSE_BRK  = 3'd3,
    CAUSE_EXC  = 3'd4
  } stall_cause_e;

  function automatic logic cause_stalls(stall_cause_e c);
    return (c == CAUSE_HAZ) || (c == CAUSE_HILO) || (c == CAUSE_BRK);
  endfunction
endpackage

// File: rtl/haz_reduce.sv
module haz_reduce #(
  parameter int N = 3
) (
  input  logic [N-1:0] haz_i,
  output logic         any_o
);
  logic [N:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_or
    assign chain[g+1] = chain[g] | haz_i[g];
  end
  assign any_o = chain[N];
endmodule

// File: rtl/exc_tracker.sv
module exc_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_req_i,
  input  logic resolved_i,
  output logic active_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= flush_req_i | (pend_q & ~resolved_i);
  end

  assign active_o = flush_req_i | pend_q;

  AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !resolved_i) |=> active_o); // R8
  AST_RESOLVE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resolved_i && !flush_req_i) |=> (active_o == flush_req_i)); // R8
endmodule

// File: rtl/brk_tracker.sv
module brk_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brk_here_i,
  input  logic exc_act_i,
  input  logic release_i,
  input  logic id_hold_i,
  output logic brk_wait_o
);
  logic seen_q;

  assign brk_wait_o = brk_here_i & ~seen_q & ~exc_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= 1'b0;
    else if (exc_act_i) seen_q <= 1'b0;
    else                seen_q <= (brk_wait_o & release_i) | (seen_q & id_hold_i);
  end

  AST_RELEASE_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_wait_o && release_i) |=> !brk_wait_o); // R4
  AST_RELEASE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !(brk_wait_o && release_i)) |=> !seen_q); // R5
  AST_FLUSH_DROPS_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_act_i |=> !seen_q); // R9
endmodule

// File: rtl/stall_cause_arb.sv
module stall_cause_arb
  import stall_pkg::*;
(
  input  logic         exc_act_i,
  input  logic         haz_i,
  input  logic         hilo_i,
  input  logic         brk_i,
  output stall_cause_e cause_o
);
  always_comb begin
    if (exc_act_i)   cause_o = CAUSE_EXC;
    else if (haz_i)  cause_o = CAUSE_HAZ;
    else if (hilo_i) cause_o = CAUSE_HILO;
    else if (brk_i)  cause_o = CAUSE_BRK;
    else             cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/pipe_stall_ctrl.sv
module pipe_stall_ctrl
  import stall_pkg::*;
#(
  parameter int NUM_HAZ = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               id_valid_i,
  input  logic [NUM_HAZ-1:0] haz_stall_i,
  input  logic               id_rd_hilo_i,
  input  logic               md_busy_i,
  input  logic               id_is_brk_i,
  input  logic               release_i,
  input  logic               exc_flush_i,
  input  logic               exc_resolved_i,
  output logic               if_freeze_o,
  output logic               id_freeze_o,
  output logic               ex_bubble_o,
  output logic               flush_o
);
  logic         haz_any, exc_act, brk_wait, dec_stall;
  stall_cause_e cause;

  haz_reduce #(.N(NUM_HAZ)) u_haz (.haz_i(haz_stall_i), .any_o(haz_any));

  exc_tracker u_exc (
    .clk_i, .rst_ni,
    .flush_req_i(exc_flush_i),
    .resolved_i (exc_resolved_i),
    .active_o   (exc_act)
  );

  brk_tracker u_brk (
    .clk_i, .rst_ni,
    .brk_here_i(id_valid_i & id_is_brk_i),
    .exc_act_i (exc_act),
    .release_i (release_i),
    .id_hold_i (dec_stall),
    .brk_wait_o(brk_wait)
  );

  stall_cause_arb u_arb (
    .exc_act_i(exc_act),
    .haz_i    (id_valid_i & haz_any),
    .hilo_i   (id_valid_i & id_rd_hilo_i & md_busy_i),
    .brk_i    (brk_wait),
    .cause_o  (cause)
  );

  assign dec_stall   = cause_stalls(cause);
  assign id_freeze_o = dec_stall;
  assign ex_bubble_o = dec_stall;
  assign flush_o     = exc_act;
  assign if_freeze_o = dec_stall | exc_act;

  AST_FLUSH_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (!id_freeze_o && !ex_bubble_o && if_freeze_o)); // R7
  AST_BUBBLE_PAIRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_bubble_o |-> (id_freeze_o && if_freeze_o)); // R2
  AST_HILO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && id_rd_hilo_i && md_busy_i && !exc_flush_i && !flush_o) |-> id_freeze_o); // R3
  AST_FLUSH_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_flush_i && !exc_resolved_i) |=> flush_o); // R8
endmodule

// File: tb/pipe_stall_ctrl_bench.sv
module pipe_stall_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NH = 4;

  logic clk = 0, rst_n = 0;
  logic id_valid = 0, hilo = 0, busy = 0, brk = 0, rel = 0, flush = 0, resolved = 0;
  logic [NH-1:0] haz = '0;
  logic if_frz, id_frz, bub, fl;

  int n_chk = 0, n_bad = 0;
  logic m_seen = 0, m_pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_stall_ctrl #(.NUM_HAZ(NH)) u_pipe_stall_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .id_valid_i(id_valid), .haz_stall_i(haz),
    .id_rd_hilo_i(hilo), .md_busy_i(busy), .id_is_brk_i(brk), .release_i(rel),
    .exc_flush_i(flush), .exc_resolved_i(resolved),
    .if_freeze_o(if_frz), .id_freeze_o(id_frz), .ex_bubble_o(bub), .flush_o(fl));

  function automatic logic e_exc();
    return flush | m_pend;
  endfunction
  function automatic logic e_brk();
    return id_valid & brk & ~m_seen & ~e_exc();
  endfunction
  function automatic logic e_stall();
    return ~e_exc() & ((id_valid & (|haz)) | (id_valid & hilo & busy) | e_brk());
  endfunction
  function automatic string auto_tag();
    if (flush) return "R7";
    if (m_pend) return "R10";
    if (e_brk()) return "R4";
    if (id_valid & hilo & busy) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag);
    logic [3:0] got, exp;
    got = {if_frz, id_frz, bub, fl};
    exp = {e_exc() | e_stall(), e_stall(), e_stall(), e_exc()};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {if_freeze,id_freeze,bubble,flush} got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Inputs are set at negedge, checked 1 time unit later, model advanced at posedge.
  task automatic step(input string tag);
    #1;
    check(tag);
    @(posedge clk);
    begin
      logic st, ex, w;
      st = e_stall(); ex = e_exc(); w = e_brk();
      m_seen = ex ? 1'b0 : ((w & rel) | (m_seen & st));
      m_pend = flush | (m_pend & ~resolved);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    id_valid = 0; haz = '0; hilo = 0; busy = 0; brk = 0; rel = 0; flush = 0; resolved = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    #1 check("R1");
    rst_n = 1;
    @(negedge clk);
    idle(); step("R1");

    // R2: each hazard bit alone, and gated by id_valid
    for (int b = 0; b < NH; b++) begin
      idle(); id_valid = 1; haz[b] = 1; step("R2");
    end
    idle(); haz = '1; step("R2");

    // R3: long multiply/divide wait, busy alone does nothing
    idle(); id_valid = 1; hilo = 1; busy = 1;
    for (int i = 0; i < 6; i++) step("R3");
    busy = 0; step("R3");
    idle(); id_valid = 1; busy = 1; step("R3");

    // R5: release with no waiting break is ignored
    idle(); rel = 1; step("R5");
    idle(); id_valid = 1; brk = 1; step("R5");
    // R4: waiting break, release pulse, stall ends next cycle
    step("R4"); step("R4");
    rel = 1; step("R4");
    rel = 0; step("R4");
    // R6: break left decode; next break waits again
    step("R6"); step("R6");

    // R4 with hazard holding decode after release
    idle(); id_valid = 1; brk = 1; rel = 1; step("R4");
    rel = 0; haz[2] = 1; step("R4");
    haz = '0; step("R4");

    // R7/R9: flush while a break holds its release, then break stalls again
    idle(); id_valid = 1; brk = 1; rel = 1; step("R9");
    rel = 0; haz[0] = 1; step("R9");
    flush = 1; hilo = 1; busy = 1; step("R7");
    flush = 0; step("R10");
    rel = 1; step("R10");
    rel = 0; resolved = 1; step("R8");
    resolved = 0; hilo = 0; busy = 0; haz = '0; step("R9");

    // R8: flush and resolve together, flush wins
    idle(); flush = 1; resolved = 1; step("R8");
    flush = 0; step("R8");
    step("R8");
    resolved = 1; step("R8");
    resolved = 0; step("R8");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      id_valid = ($urandom_range(0, 9) != 0);
      haz = ($urandom_range(0, 3) == 0) ? NH'($urandom) : '0;
      hilo = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 7) == 0) busy = ~busy;
      if ($urandom_range(0, 9) == 0) brk = ~brk;
      rel = ($urandom_range(0, 5) == 0);
      flush = ($urandom_range(0, 40) == 0);
      resolved = ($urandom_range(0, 6) == 0);
      step(auto_tag());
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule